// File: doc/BRIEF.md
# Least-Frequently-Used Victim Selector

This block tracks how often each line of a set-associative cache is used and names the way to replace when the cache must allocate. Every way of every set owns a small saturating counter. A hit strobe with its set and way bumps that line's counter. An eviction strobe with its set and way zeroes the counter of the line being replaced, so the incoming line starts fresh.

The cache controller presents a set index on the request port and reads back, in the same cycle, the way whose counter is lowest in that set. When several ways share that lowest count, the lowest-numbered one is returned, so the choice is repeatable. Counter updates land on the clock edge. Selection is purely combinational from the stored counts. Tag storage and the controller state machine sit outside the block.

Top module: `lfu_victim_sel`

## Requirements
- R1: A hit strobe (`hit_i` high) raises the counter of line (`hit_set_i`, `hit_way_i`) by exactly one at the next rising clock edge.
- R2: An eviction strobe (`evict_i` high) sets the counter of line (`evict_set_i`, `evict_way_i`) to zero at the next rising clock edge.
- R3: `victim_way_o` combinationally gives the way whose counter is smallest among the ways of set `req_set_i`. It always lies in the range 0 to NUM_WAYS-1.
- R4: When two or more ways of the requested set share the smallest counter value, `victim_way_o` gives the lowest way index among them.
- R5: A counter at its maximum value 2^CNT_W-1 keeps that value on a further hit instead of wrapping to zero.
- R6: When a hit and an eviction name the same line in the same cycle, the counter of that line becomes zero. When they name different lines, both updates apply.
- R7: The active-low asynchronous reset `rst_ni` clears every counter, so each set offers way 0 as its victim after reset.
- R8: Hits and evictions in one set leave the counters, and therefore the victim, of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; counters update on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all counters |
| hit_i | input | 1 | Hit strobe |
| hit_set_i | input | SET_W | Set index of the hit line |
| hit_way_i | input | WAY_W | Way index of the hit line |
| evict_i | input | 1 | Eviction strobe |
| evict_set_i | input | SET_W | Set index of the evicted line |
| evict_way_i | input | WAY_W | Way index of the evicted line |
| req_set_i | input | SET_W | Set whose victim is requested |
| victim_way_o | output | WAY_W | Way with the lowest count in the requested set, lowest index on ties |

## Verification
Uneven hit counts across the ways of one set confirm that the true minimum is found and not a fixed position. Equal counts confirm the tie goes to the lowest index. An eviction followed by hits that restore a tie separates a cleared counter from a merely reduced one. Driving one way past its ceiling while the others hold a count of one tells saturation from wraparound. A hit and an eviction on the same line, and then on different lines, separate clear priority from dropped updates. Requests to sets that were never touched, or were touched elsewhere, show that sets are isolated.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
  // index width that stays at least one bit for single-entry dimensions
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lfu_cnt_cell.sv
module lfu_cnt_cell #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;  // clear wins over hit
    else if (inc_i && cnt_q != CntMax)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lfu_cnt_bank.sv
module lfu_cnt_bank #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 4,
  parameter int SET_W    = 4,
  parameter int WAY_W    = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               hit_i,
  input  logic [SET_W-1:0]                   hit_set_i,
  input  logic [WAY_W-1:0]                   hit_way_i,
  input  logic                               evict_i,
  input  logic [SET_W-1:0]                   evict_set_i,
  input  logic [WAY_W-1:0]                   evict_way_i,
  output logic [NUM_SETS*NUM_WAYS*CNT_W-1:0] cnt_flat_o
);
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic hit_row, evict_row;
    assign hit_row   = hit_i   && (hit_set_i   == SET_W'(s));
    assign evict_row = evict_i && (evict_set_i == SET_W'(s));

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      localparam int Idx = s * NUM_WAYS + w;
      logic inc, clr;
      assign inc = hit_row   && (hit_way_i   == WAY_W'(w));
      assign clr = evict_row && (evict_way_i == WAY_W'(w));

      lfu_cnt_cell #(.CNT_W(CNT_W)) u_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .inc_i (inc),
        .clr_i (clr),
        .cnt_o (cnt_flat_o[Idx*CNT_W +: CNT_W])
      );
    end
  end
endmodule

// File: rtl/lfu_set_mux.sv
module lfu_set_mux #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 4,
  parameter int SET_W    = 4
) (
  input  logic [NUM_SETS*NUM_WAYS*CNT_W-1:0] cnt_flat_i,
  input  logic [SET_W-1:0]                   req_set_i,
  output logic [NUM_WAYS*CNT_W-1:0]          row_o
);
  localparam int RowW = NUM_WAYS * CNT_W;

  always_comb begin
    row_o = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (req_set_i == SET_W'(s)) row_o = cnt_flat_i[s*RowW +: RowW];
    end
  end
endmodule

// File: rtl/lfu_min_tree.sv
module lfu_min_tree #(
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 4,
  parameter int WAY_W    = 2
) (
  input  logic [NUM_WAYS*CNT_W-1:0] row_i,
  output logic [WAY_W-1:0]          way_o
);
  localparam int Lvls  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 0;
  localparam int Leafs = 1 << Lvls;
  localparam int Nodes = 2 * Leafs - 1;

  logic [Leafs*CNT_W-1:0] pad_row;

  if (Leafs > NUM_WAYS) begin : g_pad
    assign pad_row = {{((Leafs-NUM_WAYS)*CNT_W){1'b1}}, row_i};
  end else begin : g_nopad
    assign pad_row = row_i;
  end

  logic [CNT_W-1:0] node_cnt [Nodes];
  logic [WAY_W-1:0] node_way [Nodes];
  logic             node_vld [Nodes];

  always_comb begin
    for (int i = 0; i < Leafs; i++) begin
      node_cnt[Leafs-1+i] = pad_row[i*CNT_W +: CNT_W];
      node_way[Leafs-1+i] = WAY_W'(i);
      node_vld[Leafs-1+i] = (i < NUM_WAYS);
    end
    // children sit at higher indices, so descending order resolves them first
    for (int n = Leafs - 2; n >= 0; n--) begin
      logic take_l;
      take_l = node_vld[2*n+1] &&
               (!node_vld[2*n+2] || node_cnt[2*n+1] <= node_cnt[2*n+2]);
      node_cnt[n] = take_l ? node_cnt[2*n+1] : node_cnt[2*n+2];
      node_way[n] = take_l ? node_way[2*n+1] : node_way[2*n+2];
      node_vld[n] = node_vld[2*n+1] || node_vld[2*n+2];
    end
  end

  assign way_o = node_way[0];
endmodule

// File: rtl/lfu_victim_sel.sv
module lfu_victim_sel #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 4,
  localparam int SET_W   = lfu_pkg::idx_w(NUM_SETS),
  localparam int WAY_W   = lfu_pkg::idx_w(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [SET_W-1:0] hit_set_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic             evict_i,
  input  logic [SET_W-1:0] evict_set_i,
  input  logic [WAY_W-1:0] evict_way_i,
  input  logic [SET_W-1:0] req_set_i,
  output logic [WAY_W-1:0] victim_way_o
);
  logic [NUM_SETS*NUM_WAYS*CNT_W-1:0] cnt_flat;
  logic [NUM_WAYS*CNT_W-1:0]          req_row;

  lfu_cnt_bank #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W),
    .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit_i),
    .hit_set_i  (hit_set_i),
    .hit_way_i  (hit_way_i),
    .evict_i    (evict_i),
    .evict_set_i(evict_set_i),
    .evict_way_i(evict_way_i),
    .cnt_flat_o (cnt_flat)
  );

  lfu_set_mux #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .SET_W(SET_W)
  ) u_mux (
    .cnt_flat_i(cnt_flat),
    .req_set_i (req_set_i),
    .row_o     (req_row)
  );

  lfu_min_tree #(
    .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .WAY_W(WAY_W)
  ) u_tree (
    .row_i(req_row),
    .way_o(victim_way_o)
  );
endmodule

// File: rtl/lfu_victim_sel_chk.sv
module lfu_victim_sel_chk #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 4,
  parameter int SET_W    = 4,
  parameter int WAY_W    = 2
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               hit_i,
  input logic [SET_W-1:0]                   hit_set_i,
  input logic [WAY_W-1:0]                   hit_way_i,
  input logic                               evict_i,
  input logic [SET_W-1:0]                   evict_set_i,
  input logic [WAY_W-1:0]                   evict_way_i,
  input logic [SET_W-1:0]                   req_set_i,
  input logic [WAY_W-1:0]                   victim_way_o,
  input logic [NUM_SETS*NUM_WAYS*CNT_W-1:0] cnt_flat_i
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  function automatic logic [CNT_W-1:0] cnt_at(logic [SET_W-1:0] s, logic [WAY_W-1:0] w);
    return cnt_flat_i[(int'(s) * NUM_WAYS + int'(w)) * CNT_W +: CNT_W];
  endfunction

  logic same_line;
  assign same_line = hit_i && evict_i && (hit_set_i == evict_set_i) && (hit_way_i == evict_way_i);

  p_hit_inc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && !same_line && cnt_at(hit_set_i, hit_way_i) != CntMax |=>
    cnt_at($past(hit_set_i), $past(hit_way_i)) == $past(cnt_at(hit_set_i, hit_way_i)) + 1'b1);

  p_evict_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_i |=> cnt_at($past(evict_set_i), $past(evict_way_i)) == '0);

  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(victim_way_o) < NUM_WAYS);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    p_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_at(req_set_i, victim_way_o) <= cnt_at(req_set_i, WAY_W'(w)));

    p_tie_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (WAY_W'(w) < victim_way_o) |->
      cnt_at(req_set_i, WAY_W'(w)) > cnt_at(req_set_i, victim_way_o));
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && !same_line && cnt_at(hit_set_i, hit_way_i) == CntMax |=>
    cnt_at($past(hit_set_i), $past(hit_way_i)) == CntMax);

  p_clear_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same_line |=> cnt_at($past(hit_set_i), $past(hit_way_i)) == '0);
endmodule

bind lfu_victim_sel lfu_victim_sel_chk #(
  .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W),
  .SET_W(SET_W), .WAY_W(WAY_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hit_i       (hit_i),
  .hit_set_i   (hit_set_i),
  .hit_way_i   (hit_way_i),
  .evict_i     (evict_i),
  .evict_set_i (evict_set_i),
  .evict_way_i (evict_way_i),
  .req_set_i   (req_set_i),
  .victim_way_o(victim_way_o),
  .cnt_flat_i  (cnt_flat)
);

// File: tb/sim_lfu_victim_sel.sv
`timescale 1ns/1ps
module sim_lfu_victim_sel;
  localparam int NUM_SETS = 16;
  localparam int NUM_WAYS = 4;
  localparam int CNT_W    = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hit_i = 1'b0;
  logic [3:0] hit_set_i = '0;
  logic [1:0] hit_way_i = '0;
  logic       evict_i = 1'b0;
  logic [3:0] evict_set_i = '0;
  logic [1:0] evict_way_i = '0;
  logic [3:0] req_set_i = '0;
  logic [1:0] victim_way_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  lfu_victim_sel #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hit_i(hit_i), .hit_set_i(hit_set_i), .hit_way_i(hit_way_i),
    .evict_i(evict_i), .evict_set_i(evict_set_i), .evict_way_i(evict_way_i),
    .req_set_i(req_set_i), .victim_way_o(victim_way_o)
  );

  task automatic strobe(input bit h, input int hs, input int hw,
                        input bit e, input int es, input int ew);
    @(negedge clk_i);
    hit_i = h; hit_set_i = 4'(hs); hit_way_i = 2'(hw);
    evict_i = e; evict_set_i = 4'(es); evict_way_i = 2'(ew);
    @(posedge clk_i);
    #0.5;
    hit_i = 1'b0; evict_i = 1'b0;
  endtask

  task automatic hit(input int s, input int w, input int n = 1);
    for (int i = 0; i < n; i++) strobe(1'b1, s, w, 1'b0, 0, 0);
  endtask

  task automatic expect_victim(input int s, input int exp, input string tag);
    req_set_i = 4'(s);
    #0.5;
    checks++;
    if (int'(victim_way_o) != exp) begin
      errors++;
      $display("FAIL %s: set %0d victim_way_o=%0d expected %0d", tag, s, victim_way_o, exp);
    end
  endtask

  task automatic t_reset;
    for (int s = 0; s < NUM_SETS; s += 5) expect_victim(s, 0, "R7 reset");
  endtask

  task automatic t_min_and_tie;
    hit(1, 0, 2); hit(1, 1); hit(1, 2); hit(1, 3);
    expect_victim(1, 1, "R4 tie among 1,1,1");
    hit(1, 1); hit(1, 2);
    expect_victim(1, 3, "R3 minimum at way 3");
    hit(1, 3);
    expect_victim(1, 0, "R4 all equal");
    hit(2, 0);
    expect_victim(2, 1, "R1 one hit above zero");
    hit(2, 1);
    expect_victim(2, 2, "R1 increment by one");
  endtask

  task automatic t_evict;
    for (int w = 0; w < NUM_WAYS; w++) hit(3, w, 2);
    hit(3, 2, 3);
    expect_victim(3, 0, "R3 way 2 highest");
    strobe(1'b0, 0, 0, 1'b1, 3, 2);
    expect_victim(3, 2, "R2 evicted way lowest");
    hit(3, 2, 2);
    expect_victim(3, 0, "R2 cleared to zero");
  endtask

  task automatic t_saturate;
    for (int w = 1; w < NUM_WAYS; w++) hit(4, w);
    hit(4, 0, 16);
    expect_victim(4, 1, "R5 saturate not wrap");
    hit(4, 0, 5);
    expect_victim(4, 1, "R5 stays at max");
  endtask

  task automatic t_collide;
    for (int w = 0; w < NUM_WAYS; w++) hit(5, w);
    strobe(1'b1, 5, 3, 1'b1, 5, 3);
    expect_victim(5, 3, "R6 clear wins on same line");
    strobe(1'b1, 5, 0, 1'b1, 5, 1);
    expect_victim(5, 1, "R6 different lines both apply");
    hit(5, 3, 1); hit(5, 1, 1);
    expect_victim(5, 1, "R6 way1 was zero");
  endtask

  task automatic t_indep;
    hit(7, 0);
    strobe(1'b0, 0, 0, 1'b1, 9, 0);
    expect_victim(7, 1, "R8 own set updated");
    expect_victim(8, 0, "R8 neighbour untouched");
    expect_victim(0, 0, "R8 set 0 untouched");
    expect_victim(1, 0, "R8 set 1 unchanged");
    expect_victim(4, 1, "R8 set 4 unchanged");
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #0.5;
    expect_victim(2, 0, "R7 during reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_min_and_tie();
    t_evict();
    t_saturate();
    t_collide();
    t_indep();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run incomplete, expected completion");
      summary();
      $finish;
    end
  end
endmodule